// File: doc/BRIEF.md
# Programmable Integer Clock Divider

This block derives a slower timing signal from one master clock for a ratio N given at run time. It has two behaviours, chosen by a mode input. In pulse mode it produces a clock-enable strobe one master cycle wide, once every N master cycles. Downstream logic stays on the master clock and qualifies its registers with that strobe. In square-wave mode it produces a waveform whose full period is N master cycles. Even ratios give an exactly balanced duty cycle. Odd ratios give a low phase one cycle longer than the high phase.

Every register runs on the single master clock. Both outputs come straight from flops, so decode glitches cannot reach them. The ratio and mode inputs are sampled only at reset and at the end of each output period. A new setting therefore never cuts a period short. The block does not glitch-proof a ratio change. It does not use the falling clock edge. It does not drive a clock network.

Top module: `clkdiv_prog`

## Requirements
- R1: While the synchronous reset `rst` is high, `tick_o` and `wave_o` are low from the first clock edge with reset asserted, and the period counter restarts at position zero.
- R2: In pulse mode (`sq_mode_i` = 0), `tick_o` is high for exactly one master cycle per N master cycles. The first high cycle follows the N-th rising edge after reset is released.
- R3: In square-wave mode (`sq_mode_i` = 1) with even N, `wave_o` is low for N/2 cycles and then high for N/2 cycles, repeating with period N. The low phase starts at reset release.
- R4: In square-wave mode with odd N ≥ 3, `wave_o` is low for (N+1)/2 cycles and then high for (N-1)/2 cycles, repeating with period N.
- R5: With N = 1, `tick_o` is high on every cycle in pulse mode, and `wave_o` stays low in square-wave mode.
- R6: A ratio input of 0 behaves exactly like a ratio of 1.
- R7: The output of the mode that is not selected stays low. `wave_o` is low in pulse mode and `tick_o` is low in square-wave mode.
- R8: A change to `ratio_i` or `sq_mode_i` while running takes effect only at the end of the current output period. The new setting is the value present at the edge that ends the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ratio_i | input | RATIO_W | Divide ratio N (0 is taken as 1) |
| sq_mode_i | input | 1 | 0 selects pulse mode, 1 selects square-wave mode |
| tick_o | output | 1 | One-cycle enable strobe every N cycles (pulse mode) |
| wave_o | output | 1 | Divided square wave of period N (square-wave mode) |

## Verification
The period counter, the latched ratio and the latched mode together decide the outputs. If any of them is wrong, the error shows within one output period. A miscount moves the strobe or the rising edge of the wave off its expected cycle. A wrong half-period threshold shifts the duty split inside the very first period. A configuration latched at the wrong moment changes the spacing of the period in which the input changed. The bench models the period position independently and compares both outputs on every cycle. Any such drift is therefore reported in the cycle where it first appears.

// File: rtl/clkdiv_prog.sv
module clkdiv_prog #(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               sq_mode_i,
  output logic               tick_o,
  output logic               wave_o
);

  localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

  logic [RATIO_W-1:0] cnt, n_act, n_req, cnt_nx, n_nx, lo_nx;
  logic               mode_act, mode_nx, tc;

  // ratio 0 folds onto 1
  assign n_req   = (ratio_i == '0) ? ONE : ratio_i;
  assign tc      = (cnt == n_act - ONE);
  assign cnt_nx  = tc ? '0 : cnt + ONE;
  assign n_nx    = tc ? n_req : n_act;
  assign mode_nx = tc ? sq_mode_i : mode_act;
  // low phase lasts ceil(N/2) cycles
  assign lo_nx   = n_nx - (n_nx >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      n_act    <= n_req;
      mode_act <= sq_mode_i;
      tick_o   <= 1'b0;
      wave_o   <= 1'b0;
    end else begin
      cnt      <= cnt_nx;
      n_act    <= n_nx;
      mode_act <= mode_nx;
      tick_o   <= tc & ~mode_act;
      wave_o   <= mode_nx & (cnt_nx >= lo_nx);
    end
  end

endmodule

// File: rtl/clkdiv_prog_chk.sv
module clkdiv_prog_chk #(
  parameter int RATIO_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               tick_o,
  input logic               wave_o,
  input logic [RATIO_W-1:0] cnt,
  input logic [RATIO_W-1:0] n_act,
  input logic               mode_act
);

  logic seen_rst = 1'b0;
  always_ff @(posedge clk) seen_rst <= rst;

  always_ff @(posedge clk)
    if (seen_rst) AST_RST_QUIET: assert (!tick_o && !wave_o); // R1

  AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    !(tick_o && wave_o)); // R7

  AST_TICK_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (cnt == '0)); // R2

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt < n_act); // R2

  AST_WAVE_LOW_AT_START: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> !wave_o); // R4

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> ($stable(n_act) && $stable(mode_act))); // R8

  AST_N1_WAVE_LOW: assert property (@(posedge clk) disable iff (rst)
    (n_act == RATIO_W'(1)) |-> !wave_o); // R5

endmodule

bind clkdiv_prog clkdiv_prog_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk(clk), .rst(rst), .tick_o(tick_o), .wave_o(wave_o),
  .cnt(cnt), .n_act(n_act), .mode_act(mode_act)
);

// File: tb/clkdiv_prog_test.sv
`timescale 1ns/1ps
module clkdiv_prog_test;

  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [RW-1:0] ratio = 8'd4;
  logic          mode = 1'b0;
  logic          tick, wave;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int pos, cur_n;
  bit cur_m;

  always #2.5 clk = ~clk;

  clkdiv_prog #(.RATIO_W(RW)) uut (
    .clk(clk), .rst(rst), .ratio_i(ratio), .sq_mode_i(mode),
    .tick_o(tick), .wave_o(wave)
  );

  function automatic int eff(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  task automatic cmp(input string req, input bit t_exp, input bit w_exp);
    checks++;
    if (tick !== t_exp || wave !== w_exp) begin
      errors++;
      $display("FAIL %s: tick/wave = %b%b expected %b%b at %0t",
               req, tick, wave, t_exp, w_exp, $time);
    end
  endtask

  task automatic do_reset(input int n, input bit m);
    @(negedge clk);
    rst = 1'b1; ratio = RW'(n); mode = m;
    repeat (2) begin
      @(negedge clk);
      cmp("R1 reset", 1'b0, 1'b0);
    end
    pos = 0; cur_n = eff(n); cur_m = m;
    rst = 1'b0;
  endtask

  // one master cycle: model the edge, then compare away from it
  task automatic step(input string req);
    bit te, we;
    @(posedge clk);
    pos++;
    if (pos >= cur_n) begin
      te = !cur_m; we = 1'b0;
      pos = 0; cur_n = eff(int'(ratio)); cur_m = mode;
    end else begin
      te = 1'b0;
      we = cur_m && (pos >= (cur_n + 1) / 2);
    end
    @(negedge clk);
    cmp(req, te, we);
  endtask

  task automatic run(input int n, input bit m, input int cyc, input string req);
    do_reset(n, m);
    for (int i = 0; i < cyc; i++) step(req);
  endtask

  task automatic t_reset();
    run(5, 1'b1, 7, "R4 pre-reset");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); cmp("R1 mid-run reset", 1'b0, 1'b0);
    @(negedge clk); cmp("R1 held reset", 1'b0, 1'b0);
    pos = 0; cur_n = 5; cur_m = 1'b1; rst = 1'b0;
    for (int i = 0; i < 10; i++) step("R1 restart from zero");
  endtask

  task automatic t_pulse();
    run(5, 1'b0, 21, "R2 N=5 pulse / R7 wave low");
    run(2, 1'b0, 10, "R2 N=2 pulse");
    run(13, 1'b0, 40, "R2 N=13 pulse");
  endtask

  task automatic t_square_even();
    run(6, 1'b1, 25, "R3 N=6 square / R7 tick low");
    run(2, 1'b1, 10, "R3 N=2 square");
    run(10, 1'b1, 30, "R3 N=10 square");
  endtask

  task automatic t_square_odd();
    run(3, 1'b1, 13, "R4 N=3 square");
    run(7, 1'b1, 22, "R4 N=7 square");
    run(255, 1'b1, 520, "R4 N=255 square");
  endtask

  task automatic t_one();
    run(1, 1'b0, 8, "R5 N=1 pulse every cycle");
    run(1, 1'b1, 8, "R5 N=1 square held low");
  endtask

  task automatic t_zero();
    run(0, 1'b0, 8, "R6 N=0 pulse as N=1");
    run(0, 1'b1, 8, "R6 N=0 square as N=1");
  endtask

  task automatic t_change();
    do_reset(4, 1'b0);
    step("R8 ratio change"); step("R8 ratio change");
    ratio = 8'd3;
    for (int i = 0; i < 12; i++) step("R8 ratio change mid-period");
    mode = 1'b1; ratio = 8'd6;
    for (int i = 0; i < 20; i++) step("R8 mode change to square");
    ratio = 8'd5; mode = 1'b0;
    for (int i = 0; i < 16; i++) step("R8 back to pulse N=5");
  endtask

  initial begin
    t_reset();
    t_pulse();
    t_square_even();
    t_square_odd();
    t_one();
    t_zero();
    t_change();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule